// File: doc/BRIEF.md
# Round-Robin Password Candidate Dispatcher

This block walks through every string of a chosen length over a chosen alphabet and deals those strings out to a bank of parallel hash cores. The strings come out in odometer order: the rightmost character steps fastest, and a position carries into its left neighbour when it wraps. Each character position is held as an index into the active alphabet. A small per-position lookup turns that index into ASCII, so alphabets whose pieces are not next to each other in ASCII cost nothing extra.

The cores are served in strict rotation: core 0, core 1, and so on up to core N-1, then core 0 again. Only the core whose turn it is sees a valid offer. The block waits on that core for as long as its ready is low. It skips no core and drops no string. Every offered string carries a sequence tag, and the index of the core it was offered to travels beside it. When a core later reports a hit, the host can rebuild the password from the tag alone.

Configuration is plain control: an alphabet select, a length, and start and stop pulses. A start latches the configuration and begins again from the first string. Stop and exhaustion both end the issue of strings.

Top module: `cand_dispatch`

## Requirements
- R1: After reset no core sees a valid offer. `busy` and `exhausted` are 0, and `cand_tag` is 0.
- R2: A start pulse latches `cfg_charset` and `cfg_len` and sets every position to alphabet index 0. It then offers the first string to core 0 with tag 0. Character position p (p = 0 is leftmost) is carried in `cand_data[8p+7:8p]`, and bytes at positions at or beyond the length are 0x00.
- R3: Strings follow odometer order. The string with tag t has, at its rightmost position, alphabet index t mod S, where S is the alphabet size. Each position further left takes the next base-S digit of t.
- R4: Alphabet select codes map index to ASCII as follows. Code 0 is a–z (S=26). Code 1 is a–z then 0–9 (S=36). Code 2 is a–z then A–Z (S=52). Code 3 is a–z, then A–Z, then 0–9 (S=62).
- R5: At most one bit of `core_valid` is high, and it is the core `cand_core`. The string with tag t goes to core t mod N.
- R6: While the offered core holds ready low, `core_valid`, `cand_data`, `cand_tag` and `cand_core` hold their values. A transfer happens on a clock edge where the offered core's ready and valid are both high.
- R7: Each transfer raises `cand_tag` by exactly one.
- R8: After the transfer of the last string (every active position at index S-1), `exhausted` goes to 1 and `busy` goes to 0. From then on no valid offer is made. Exactly S^len strings are issued in total.
- R9: A stop pulse removes every valid offer and clears `busy` from the next cycle onward. A transfer in the same cycle as the stop still counts.
- R10: A start after a stop or after exhaustion clears `exhausted` and restarts at the first string with tag 0 and core 0.
- R11: Changes on `cfg_charset` or `cfg_len` while a run is going on have no effect on the strings offered until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_charset | input | 2 | Alphabet select code (see R4) |
| cfg_len | input | LEN_W | String length, 1 to MAX_LEN |
| start | input | 1 | Pulse: latch configuration and begin from the first string |
| stop | input | 1 | Pulse: end issue |
| core_ready | input | NUM_CORES | Per-core ready |
| core_valid | output | NUM_CORES | Per-core valid, at most one high |
| cand_data | output | MAX_LEN*8 | Offered string, leftmost character in the low byte |
| cand_tag | output | SEQ_W | Sequence number of the offered string |
| cand_core | output | CORE_W | Index of the core being offered to |
| busy | output | 1 | A run is in progress |
| exhausted | output | 1 | The last string has been issued |

## Verification
The bench aims at carry handling across position boundaries. A design with a broken carry chain would repeat or skip strings at the zz-to-next wrap, and the tag-to-string model catches that at the first mismatch. The bench checks all four alphabets, including the seams where letters give way to digits or to capitals, where a wrong offset shows up as a wrong byte. Pseudo-random back-pressure targets a rotation that advances while a core is not ready, which would show up as a skipped core or a string offered twice. The remaining targets are an exhausted flag raised one string early or late, a transfer lost in the cycle where stop arrives, and a configuration that leaks in mid-run without a start.

// File: rtl/cd_pkg.sv
package cd_pkg;

  localparam int DIG_W = 6;

  typedef enum logic [1:0] {
    CS_LOWER     = 2'd0,
    CS_LOWER_DIG = 2'd1,
    CS_MIXED     = 2'd2,
    CS_FULL      = 2'd3
  } cset_e;

  function automatic logic [6:0] alpha_size(cset_e cs);
    case (cs)
      CS_LOWER:     return 7'd26;
      CS_LOWER_DIG: return 7'd36;
      CS_MIXED:     return 7'd52;
      default:      return 7'd62;
    endcase
  endfunction

  function automatic logic [7:0] sym_ascii(cset_e cs, logic [DIG_W-1:0] idx);
    logic [7:0] wide;
    wide = {2'b00, idx};
    if (wide < 8'd26) return 8'h61 + wide;
    case (cs)
      CS_LOWER_DIG: return 8'h30 + (wide - 8'd26);
      CS_MIXED:     return 8'h41 + (wide - 8'd26);
      CS_FULL:      return (wide < 8'd52) ? (8'h41 + (wide - 8'd26))
                                          : (8'h30 + (wide - 8'd52));
      default:      return 8'h3f;
    endcase
  endfunction

endpackage

// File: rtl/cd_odometer.sv
module cd_odometer
  import cd_pkg::*;
#(
  parameter int MAX_LEN = 8,
  parameter int LEN_W   = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clear,
  input  logic                     step,
  input  logic [6:0]               size,
  input  logic [LEN_W-1:0]         len,
  output logic [MAX_LEN*DIG_W-1:0] digits,
  output logic                     all_max
);

  logic [MAX_LEN*DIG_W-1:0] dig_q, dig_nxt;
  logic carry, at_max;
  int   li;

  // Carry ripples from the rightmost active position toward position 0.
  always_comb begin
    li      = int'(len);
    carry   = 1'b0;
    at_max  = 1'b0;
    dig_nxt = dig_q;
    for (int i = MAX_LEN - 1; i >= 0; i--) begin
      if (i >= li)           carry = 1'b0;
      else if (i == li - 1)  carry = 1'b1;
      at_max = ({1'b0, dig_q[i*DIG_W +: DIG_W]} == (size - 7'd1));
      if (carry)
        dig_nxt[i*DIG_W +: DIG_W] = at_max ? '0 : dig_q[i*DIG_W +: DIG_W] + DIG_W'(1);
      carry = carry & at_max;
    end
    all_max = carry;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     dig_q <= '0;
    else if (clear) dig_q <= '0;
    else if (step)  dig_q <= dig_nxt;
  end

  assign digits = dig_q;

  for (genvar g = 0; g < MAX_LEN; g++) begin : g_chk
    AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (g < int'(len)) |-> ({1'b0, dig_q[g*DIG_W +: DIG_W]} < size)); // R3
    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (g >= int'(len)) |-> (dig_q[g*DIG_W +: DIG_W] == '0)); // R2
  end

endmodule

// File: rtl/cd_symbol_map.sv
module cd_symbol_map
  import cd_pkg::*;
#(
  parameter int MAX_LEN = 8,
  parameter int LEN_W   = 4
) (
  input  cset_e                    cs,
  input  logic [LEN_W-1:0]         len,
  input  logic [MAX_LEN*DIG_W-1:0] digits,
  output logic [MAX_LEN*8-1:0]     chars
);

  for (genvar p = 0; p < MAX_LEN; p++) begin : g_pos
    assign chars[p*8 +: 8] = (p < int'(len)) ? sym_ascii(cs, digits[p*DIG_W +: DIG_W])
                                             : 8'h00;
  end

endmodule

// File: rtl/cd_rotator.sv
module cd_rotator #(
  parameter int NUM_CORES = 4,
  parameter int CORE_W    = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 advance,
  input  logic                 offer,
  output logic [CORE_W-1:0]    ptr,
  output logic [NUM_CORES-1:0] valid_vec
);

  logic [CORE_W-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       ptr_q <= '0;
    else if (clear)   ptr_q <= '0;
    else if (advance) ptr_q <= (ptr_q == CORE_W'(NUM_CORES - 1)) ? '0 : ptr_q + CORE_W'(1);
  end

  assign ptr = ptr_q;

  for (genvar k = 0; k < NUM_CORES; k++) begin : g_vld
    assign valid_vec[k] = offer && (ptr_q == CORE_W'(k));
  end

  AST_ONE_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(valid_vec)); // R5
  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ptr_q) < NUM_CORES); // R5

endmodule

// File: rtl/cand_dispatch.sv
module cand_dispatch
  import cd_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int MAX_LEN   = 8,
  parameter int SEQ_W     = 64,
  localparam int LEN_W    = $clog2(MAX_LEN + 1),
  localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           cfg_charset,
  input  logic [LEN_W-1:0]     cfg_len,
  input  logic                 start,
  input  logic                 stop,
  input  logic [NUM_CORES-1:0] core_ready,
  output logic [NUM_CORES-1:0] core_valid,
  output logic [MAX_LEN*8-1:0] cand_data,
  output logic [SEQ_W-1:0]     cand_tag,
  output logic [CORE_W-1:0]    cand_core,
  output logic                 busy,
  output logic                 exhausted
);

  cset_e                    cs_q;
  logic [LEN_W-1:0]         len_q, len_in;
  logic                     run_q, exh_q;
  logic [SEQ_W-1:0]         tag_q;
  logic [CORE_W-1:0]        ptr;
  logic [MAX_LEN*DIG_W-1:0] digits;
  logic                     last_one, fire;

  assign fire = run_q && core_ready[ptr] && !start;

  always_comb begin
    if (cfg_len == '0)                         len_in = LEN_W'(1);
    else if (int'(cfg_len) > MAX_LEN)          len_in = LEN_W'(MAX_LEN);
    else                                       len_in = cfg_len;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_q  <= CS_LOWER;
      len_q <= LEN_W'(1);
      run_q <= 1'b0;
      exh_q <= 1'b0;
      tag_q <= '0;
    end else if (start) begin
      cs_q  <= cset_e'(cfg_charset);
      len_q <= len_in;
      run_q <= 1'b1;
      exh_q <= 1'b0;
      tag_q <= '0;
    end else begin
      if (fire) begin
        tag_q <= tag_q + SEQ_W'(1);
        if (last_one) begin
          exh_q <= 1'b1;
          run_q <= 1'b0;
        end
      end
      if (stop) run_q <= 1'b0;
    end
  end

  cd_odometer #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_odo (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (start),
    .step    (fire),
    .size    (alpha_size(cs_q)),
    .len     (len_q),
    .digits  (digits),
    .all_max (last_one)
  );

  cd_symbol_map #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_map (
    .cs     (cs_q),
    .len    (len_q),
    .digits (digits),
    .chars  (cand_data)
  );

  cd_rotator #(.NUM_CORES(NUM_CORES), .CORE_W(CORE_W)) u_rot (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (start),
    .advance   (fire),
    .offer     (run_q),
    .ptr       (ptr),
    .valid_vec (core_valid)
  );

  assign cand_tag  = tag_q;
  assign cand_core = ptr;
  assign busy      = run_q;
  assign exhausted = exh_q;

  AST_HOLD_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !core_ready[cand_core] && !stop && !start) |=>
      ($stable(core_valid) && $stable(cand_data) && $stable(cand_tag) && $stable(cand_core))); // R6
  AST_TAG_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(core_valid & core_ready)) && !start) |=> (cand_tag == $past(cand_tag) + SEQ_W'(1))); // R7
  AST_EXHAUSTED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    exhausted |-> (core_valid == '0)); // R8
  AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !start) |=> (!busy && core_valid == '0)); // R9

endmodule

// File: tb/cand_dispatch_test.sv
`timescale 1ns/1ps
module cand_dispatch_test;

  localparam int N      = 4;
  localparam int ML     = 8;
  localparam int LEN_W  = 4;
  localparam int CORE_W = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [1:0]        cfg_charset = 2'd0;
  logic [LEN_W-1:0]  cfg_len = 4'd1;
  logic              start = 1'b0, stop = 1'b0;
  logic [N-1:0]      core_ready = '0;
  logic [N-1:0]      core_valid;
  logic [ML*8-1:0]   cand_data;
  logic [63:0]       cand_tag;
  logic [CORE_W-1:0] cand_core;
  logic              busy, exhausted;

  int n_chk = 0, n_fail = 0;
  logic [7:0] lfsr = 8'hA5;

  always #4 clk = ~clk;

  cand_dispatch #(.NUM_CORES(N), .MAX_LEN(ML), .SEQ_W(64)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_charset(cfg_charset), .cfg_len(cfg_len),
    .start(start), .stop(stop), .core_ready(core_ready), .core_valid(core_valid),
    .cand_data(cand_data), .cand_tag(cand_tag), .cand_core(cand_core),
    .busy(busy), .exhausted(exhausted)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic string alphabet(input int cs);
    string lo, up, dg;
    lo = "abcdefghijklmnopqrstuvwxyz";
    up = "ABCDEFGHIJKLMNOPQRSTUVWXYZ";
    dg = "0123456789";
    case (cs)
      0: return lo;
      1: return {lo, dg};
      2: return {lo, up};
      default: return {lo, up, dg};
    endcase
  endfunction

  function automatic logic [63:0] exp_cand(input int cs, input int len, input longint idx);
    string a;
    logic [63:0] r;
    longint v;
    a = alphabet(cs);
    r = '0;
    v = idx;
    for (int p = len - 1; p >= 0; p--) begin
      r[p*8 +: 8] = a[int'(v % a.len())];
      v = v / a.len();
    end
    return r;
  endfunction

  function automatic longint total_of(input int cs, input int len);
    longint t;
    t = 1;
    for (int i = 0; i < len; i++) t = t * alphabet(cs).len();
    return t;
  endfunction

  // Entered and left at a negedge.
  task automatic do_start(input int cs, input int len);
    cfg_charset = 2'(cs);
    cfg_len     = 4'(len);
    core_ready  = '0;
    start       = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // Checks offers for tags first..upto-1, with optional back-pressure and mid-run config change.
  task automatic drive(input int cs, input int len, input longint upto, input bit bp,
                       input bit mid_change, input string req);
    longint idx;
    logic [63:0] prev_data;
    idx = 0;
    prev_data = '0;
    while (idx < upto) begin
      chk(core_valid == N'(1 << (idx % N)), req, "valid vector", 64'(core_valid), 64'(1 << (idx % N)));
      chk(cand_core == CORE_W'(idx % N), req, "core index", 64'(cand_core), 64'(idx % N));
      chk(cand_tag == 64'(idx), req, "tag", cand_tag, 64'(idx));
      chk(cand_data == exp_cand(cs, len, idx), req, "string", cand_data, exp_cand(cs, len, idx));
      if (mid_change && idx == 20) begin
        cfg_charset = 2'(3 - cs);
        cfg_len     = 4'(len == 8 ? 1 : len + 1);
      end
      if (bp) begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        core_ready = lfsr[N-1:0];
      end else begin
        core_ready = '1;
      end
      if (core_ready[idx % N]) idx++;
      prev_data = cand_data;
      @(negedge clk);
    end
    core_ready = '0;
  endtask

  task automatic t_reset;
    chk(core_valid == '0, "R1", "valid after reset", 64'(core_valid), 64'(0));
    chk(!busy, "R1", "busy after reset", 64'(busy), 64'(0));
    chk(!exhausted, "R1", "exhausted after reset", 64'(exhausted), 64'(0));
    chk(cand_tag == '0, "R1", "tag after reset", cand_tag, 64'(0));
  endtask

  task automatic check_exhausted(input longint total, input string req);
    core_ready = '1;
    for (int c = 0; c < 3; c++) begin
      chk(exhausted, req, "exhausted flag", 64'(exhausted), 64'(1));
      chk(!busy, req, "busy after last", 64'(busy), 64'(0));
      chk(core_valid == '0, req, "no offer after last", 64'(core_valid), 64'(0));
      chk(cand_tag == 64'(total), req, "issued count", cand_tag, 64'(total));
      @(negedge clk);
    end
    core_ready = '0;
  endtask

  // R4, R3, R5, R7, R8: full alphabet, single position, to the end.
  task automatic t_full_alphabet;
    do_start(3, 1);
    chk(cand_data == 64'h61 && busy, "R2", "first string", cand_data, 64'h61);
    drive(3, 1, total_of(3, 1), 1'b0, 1'b0, "R4");
    check_exhausted(total_of(3, 1), "R8");
  endtask

  // R6, R3: two positions with pseudo-random back-pressure, to the end.
  task automatic t_backpressure;
    do_start(0, 2);
    drive(0, 2, total_of(0, 2), 1'b1, 1'b0, "R6");
    check_exhausted(total_of(0, 2), "R8");
  endtask

  // R11 then R9: config change mid-run, then stop with a transfer in the stop cycle.
  task automatic t_cfg_then_stop;
    logic [63:0] tag_seen;
    do_start(1, 3);
    drive(1, 3, 200, 1'b0, 1'b1, "R11");
    core_ready = '1;
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    tag_seen = cand_tag;
    chk(tag_seen == 64'd201, "R9", "transfer in stop cycle counted", tag_seen, 64'd201);
    for (int c = 0; c < 3; c++) begin
      chk(core_valid == '0 && !busy, "R9", "no offer after stop", 64'(core_valid), 64'(0));
      chk(cand_tag == tag_seen, "R9", "tag frozen after stop", cand_tag, tag_seen);
      @(negedge clk);
    end
    core_ready = '0;
  endtask

  // R10, R2: restart after stop with a longer length, and short length byte padding.
  task automatic t_restart;
    do_start(2, 8);
    chk(cand_data == 64'h6161616161616161, "R10", "restart first string", cand_data, 64'h6161616161616161);
    chk(cand_tag == '0 && cand_core == '0, "R10", "restart tag/core", cand_tag, 64'(0));
    drive(2, 8, 120, 1'b0, 1'b0, "R3");
    do_start(2, 5);
    chk(cand_data[63:40] == '0, "R2", "bytes beyond length", 64'(cand_data[63:40]), 64'(0));
    drive(2, 5, 60, 1'b1, 1'b0, "R2");
    do_start(0, 1);
    drive(0, 1, 26, 1'b0, 1'b0, "R5");
    check_exhausted(26, "R8");
    do_start(1, 2);
    chk(!exhausted && busy, "R10", "exhausted cleared by start", 64'(exhausted), 64'(0));
    drive(1, 2, 80, 1'b0, 1'b0, "R10");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full_alphabet();
    t_backpressure();
    t_cfg_then_stop();
    t_restart();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule